// File: doc/BRIEF.md
# Banked Stack Pointer Unit

This block keeps the stack address state for a small processor core. It holds two stack pointers, a main pointer and a process pointer. A one-bit select picks which of them is active, and every push or pop reads and moves only the active pointer. For each push or pop the unit returns the byte address the memory access must use. It then moves the active pointer by one 16-bit word, which is two bytes.

A two-bit mode input chooses one of four stack conventions and is held steady during operation. The stack can grow up or down, and the pointer can point at the last item stored ("full") or at the next free slot ("empty"). During boot, a strobe loads the main pointer with the word the core fetched from vector address zero. A direct write port lets the core overwrite either pointer. Pointers must stay even. An odd value is stored with its low bit cleared, and the alignment fault output is raised.

Top module: `stack_ptr_unit`

## Requirements
- R1: After synchronous reset both pointers read 0 and `align_fault_o` and `proto_err_o` are 0.
- R2: Mode 2'b00 (grow down, pointer on last item): a push addresses SP-2 and leaves SP-2; a pop addresses SP and leaves SP+2.
- R3: Mode 2'b01 (grow down, pointer on free slot): a push addresses SP and leaves SP-2; a pop addresses SP+2 and leaves SP+2.
- R4: Mode 2'b10 (grow up, pointer on last item): a push addresses SP+2 and leaves SP+2; a pop addresses SP and leaves SP-2.
- R5: Mode 2'b11 (grow up, pointer on free slot): a push addresses SP and leaves SP+2; a pop addresses SP-2 and leaves SP-2.
- R6: `bank_sel_i`=0 makes the main pointer active and 1 makes the process pointer active. A push or pop changes only the active pointer.
- R7: A cycle with `rst_load_i` high sets the main pointer to `rst_data_i` at the next clock edge. `rst_data_i` is the word fetched from vector address 0x0.
- R8: A stored odd value from a direct write or a reset load has bit 0 cleared. `align_fault_o` is 1 for exactly the following cycle.
- R9: Push and pop high in the same cycle leave both pointers unchanged. `proto_err_o` is then 1 for exactly the following cycle.
- R10: Changing `bank_sel_i` alone changes neither stored pointer. `active_sp_o` follows the select in the same cycle.
- R11: On the main pointer, a reset load overrides a direct write, and a direct write overrides a push or pop.
- R12: With neither push nor pop, `mem_addr_o` equals the active pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Push request this cycle |
| pop_i | input | 1 | Pop request this cycle |
| bank_sel_i | input | 1 | Active pointer: 0 main, 1 process |
| mode_i | input | 2 | Stack convention, see R2 to R5 |
| rst_load_i | input | 1 | Load main pointer from reset fetch |
| rst_data_i | input | AW | Word fetched from vector address 0 |
| wr_en_i | input | 1 | Direct pointer write |
| wr_bank_i | input | 1 | Pointer targeted by the write: 0 main, 1 process |
| wr_data_i | input | AW | Value for the direct write |
| mem_addr_o | output | AW | Byte address for the current push or pop |
| main_sp_o | output | AW | Main pointer value |
| proc_sp_o | output | AW | Process pointer value |
| active_sp_o | output | AW | Value of the selected pointer |
| align_fault_o | output | 1 | Odd value was stored (one cycle) |
| proto_err_o | output | 1 | Push and pop collided (one cycle) |

## Verification
The bench runs a push and a pop from the same start value in each of the four modes. A design that swapped pre-adjust and post-adjust would be off by one word in either the address or the new pointer. It moves the process pointer while the main one is idle, which catches a design that updates the wrong bank or both banks. It drives colliding push and pop, odd writes and odd reset loads, and overlapping write sources. A wrong design would move a pointer, store an odd address, miss or stretch the one-cycle flags, or let a lower-priority source win.

// File: rtl/stkp_pkg.sv
package stkp_pkg;

    typedef enum logic [1:0] {
        STK_FULL_DESC  = 2'b00,
        STK_EMPTY_DESC = 2'b01,
        STK_FULL_ASC   = 2'b10,
        STK_EMPTY_ASC  = 2'b11
    } stk_mode_e;

    typedef enum logic [1:0] {
        OP_NONE     = 2'b00,
        OP_PUSH     = 2'b01,
        OP_POP      = 2'b10,
        OP_CONFLICT = 2'b11
    } stk_op_e;

    // Which way an operation moves the pointer and where the access lands
    typedef struct packed {
        logic update;      // pointer changes this cycle
        logic toward_up;   // new pointer = SP + step
        logic use_moved;   // access address is the moved pointer
    } stk_plan_t;

    function automatic stk_op_e decode_op(input logic push, input logic pop);
        return stk_op_e'({pop, push});
    endfunction

    function automatic logic mode_ascending(input stk_mode_e m);
        return m[1];
    endfunction

    function automatic logic mode_empty(input stk_mode_e m);
        return m[0];
    endfunction

    function automatic stk_plan_t make_plan(input stk_mode_e m, input stk_op_e op);
        stk_plan_t p;
        p = '0;
        case (op)
            OP_PUSH: begin
                p.update    = 1'b1;
                p.toward_up = mode_ascending(m);
                p.use_moved = !mode_empty(m);
            end
            OP_POP: begin
                p.update    = 1'b1;
                p.toward_up = !mode_ascending(m);
                p.use_moved = mode_empty(m);
            end
            default: p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/stkp_addr_gen.sv
module stkp_addr_gen
    import stkp_pkg::*;
#(
    parameter int AW   = 16,
    parameter int STEP = 2
) (
    input  logic [AW-1:0] sp_i,
    input  stk_mode_e     mode_i,
    input  stk_op_e       op_i,
    output logic [AW-1:0] addr_o,
    output logic [AW-1:0] next_o,
    output logic          update_o
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    stk_plan_t       plan;
    logic [AW-1:0]   sp_up;
    logic [AW-1:0]   sp_down;
    logic [AW-1:0]   moved;

    always_comb begin
        plan     = make_plan(mode_i, op_i);
        sp_up    = sp_i + STEP_V;
        sp_down  = sp_i - STEP_V;
        moved    = plan.toward_up ? sp_up : sp_down;
        update_o = plan.update;
        next_o   = plan.update ? moved : sp_i;
        addr_o   = (plan.update && plan.use_moved) ? moved : sp_i;
    end
endmodule

// File: rtl/stkp_align.sv
module stkp_align #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] val_i,
    output logic [AW-1:0] clean_o,
    output logic          odd_o
);
    always_comb begin
        odd_o   = val_i[0];
        clean_o = {val_i[AW-1:1], 1'b0};
    end
endmodule

// File: rtl/stkp_bank_regs.sv
module stkp_bank_regs #(
    parameter int AW    = 16,
    parameter int NBANK = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NBANK-1:0]          load_en_i,
    input  logic [NBANK-1:0][AW-1:0]  load_val_i,
    output logic [NBANK-1:0][AW-1:0]  sp_o
);
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [AW-1:0] sp_q;
        always_ff @(posedge clk) begin
            if (rst)               sp_q <= '0;
            else if (load_en_i[b]) sp_q <= load_val_i[b];
        end
        assign sp_o[b] = sp_q;

        AST_BANK_EVEN: assert property (@(posedge clk) disable iff (rst)
            load_en_i[b] |=> !sp_q[0]);  // R8
    end
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
    import stkp_pkg::*;
#(
    parameter int AW   = 16,
    parameter int STEP = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic          bank_sel_i,
    input  logic [1:0]    mode_i,
    input  logic          rst_load_i,
    input  logic [AW-1:0] rst_data_i,
    input  logic          wr_en_i,
    input  logic          wr_bank_i,
    input  logic [AW-1:0] wr_data_i,
    output logic [AW-1:0] mem_addr_o,
    output logic [AW-1:0] main_sp_o,
    output logic [AW-1:0] proc_sp_o,
    output logic [AW-1:0] active_sp_o,
    output logic          align_fault_o,
    output logic          proto_err_o
);
    localparam int NBANK = 2;
    localparam int MAIN  = 0;
    localparam int PROC  = 1;

    stk_op_e                   op;
    logic [AW-1:0]             active_sp;
    logic [AW-1:0]             op_next;
    logic                      op_update;
    logic [AW-1:0]             wr_clean;
    logic                      wr_odd;
    logic [AW-1:0]             ld_clean;
    logic                      ld_odd;
    logic [NBANK-1:0]          load_en;
    logic [NBANK-1:0][AW-1:0]  load_val;
    logic [NBANK-1:0][AW-1:0]  sp;
    logic                      wr_taken;
    logic                      fault_q;
    logic                      err_q;

    assign op        = decode_op(push_i, pop_i);
    assign active_sp = bank_sel_i ? sp[PROC] : sp[MAIN];

    stkp_addr_gen #(.AW(AW), .STEP(STEP)) u_addr (
        .sp_i     (active_sp),
        .mode_i   (stk_mode_e'(mode_i)),
        .op_i     (op),
        .addr_o   (mem_addr_o),
        .next_o   (op_next),
        .update_o (op_update)
    );

    stkp_align #(.AW(AW)) u_align_wr (
        .val_i   (wr_data_i),
        .clean_o (wr_clean),
        .odd_o   (wr_odd)
    );

    stkp_align #(.AW(AW)) u_align_ld (
        .val_i   (rst_data_i),
        .clean_o (ld_clean),
        .odd_o   (ld_odd)
    );

    // Source priority per bank: reset load, then direct write, then stack op
    always_comb begin
        load_en  = '0;
        load_val = '0;
        wr_taken = 1'b0;
        if (rst_load_i) begin
            load_en[MAIN]  = 1'b1;
            load_val[MAIN] = ld_clean;
        end else if (wr_en_i && wr_bank_i == 1'b0) begin
            load_en[MAIN]  = 1'b1;
            load_val[MAIN] = wr_clean;
            wr_taken       = 1'b1;
        end else if (op_update && bank_sel_i == 1'b0) begin
            load_en[MAIN]  = 1'b1;
            load_val[MAIN] = op_next;
        end

        if (wr_en_i && wr_bank_i == 1'b1) begin
            load_en[PROC]  = 1'b1;
            load_val[PROC] = wr_clean;
            wr_taken       = 1'b1;
        end else if (op_update && bank_sel_i == 1'b1) begin
            load_en[PROC]  = 1'b1;
            load_val[PROC] = op_next;
        end
    end

    stkp_bank_regs #(.AW(AW), .NBANK(NBANK)) u_banks (
        .clk        (clk),
        .rst        (rst),
        .load_en_i  (load_en),
        .load_val_i (load_val),
        .sp_o       (sp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            fault_q <= (rst_load_i && ld_odd) || (wr_taken && wr_odd);
            err_q   <= (op == OP_CONFLICT);
        end
    end

    assign main_sp_o     = sp[MAIN];
    assign proc_sp_o     = sp[PROC];
    assign active_sp_o   = active_sp;
    assign align_fault_o = fault_q;
    assign proto_err_o   = err_q;

    AST_CONFLICT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (push_i && pop_i && !wr_en_i && !rst_load_i)
            |=> ($stable(main_sp_o) && $stable(proc_sp_o) && proto_err_o));  // R9

    AST_IDLE_PROC: assert property (@(posedge clk) disable iff (rst)
        (!wr_en_i && !bank_sel_i) |=> $stable(proc_sp_o));  // R6

    AST_IDLE_MAIN: assert property (@(posedge clk) disable iff (rst)
        (!wr_en_i && !rst_load_i && bank_sel_i) |=> $stable(main_sp_o));  // R6

    AST_RESET_LOAD: assert property (@(posedge clk) disable iff (rst)
        rst_load_i |=> (main_sp_o == {$past(rst_data_i[AW-1:1]), 1'b0}));  // R7

    AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        align_fault_o |-> $past((wr_en_i && wr_data_i[0]) || (rst_load_i && rst_data_i[0])));  // R8

    AST_IDLE_ADDR: assert property (@(posedge clk) disable iff (rst)
        (!push_i && !pop_i) |-> (mem_addr_o == active_sp_o));  // R12

endmodule

// File: tb/stack_ptr_unit_test.sv
module stack_ptr_unit_test;
    localparam int AW       = 16;
    localparam time CLK_PER = 10;

    logic          clk = 1'b0;
    logic          rst;
    logic          push_i, pop_i, bank_sel_i;
    logic [1:0]    mode_i;
    logic          rst_load_i;
    logic [AW-1:0] rst_data_i;
    logic          wr_en_i, wr_bank_i;
    logic [AW-1:0] wr_data_i;
    logic [AW-1:0] mem_addr_o, main_sp_o, proc_sp_o, active_sp_o;
    logic          align_fault_o, proto_err_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PER/2) clk = ~clk;

    stack_ptr_unit #(.AW(AW), .STEP(2)) uut (
        .clk(clk), .rst(rst), .push_i(push_i), .pop_i(pop_i),
        .bank_sel_i(bank_sel_i), .mode_i(mode_i), .rst_load_i(rst_load_i),
        .rst_data_i(rst_data_i), .wr_en_i(wr_en_i), .wr_bank_i(wr_bank_i),
        .wr_data_i(wr_data_i), .mem_addr_o(mem_addr_o), .main_sp_o(main_sp_o),
        .proc_sp_o(proc_sp_o), .active_sp_o(active_sp_o),
        .align_fault_o(align_fault_o), .proto_err_o(proto_err_o)
    );

    task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        push_i = 0; pop_i = 0; rst_load_i = 0; wr_en_i = 0;
        wr_bank_i = 0; wr_data_i = '0; rst_data_i = '0;
    endtask

    // Advance one clock; results are sampled 1 time unit after the edge
    task automatic step();
        @(posedge clk);
        #1;
        clear_in();
    endtask

    task automatic write_sp(input logic bank, input logic [AW-1:0] v);
        wr_en_i = 1; wr_bank_i = bank; wr_data_i = v;
        step();
    endtask

    task automatic t_reset();
        rst = 1; clear_in(); bank_sel_i = 0; mode_i = 2'b00;
        step(); step();
        rst = 0;
        check("R1 main", main_sp_o, 16'h0);
        check("R1 proc", proc_sp_o, 16'h0);
        check("R1 fault", {15'b0, align_fault_o}, 16'h0);
        check("R1 err", {15'b0, proto_err_o}, 16'h0);
    endtask

    task automatic t_mode(input logic [1:0] m, input string tag,
                          input logic [AW-1:0] push_addr, input logic [AW-1:0] push_sp,
                          input logic [AW-1:0] pop_addr);
        bank_sel_i = 0; mode_i = m;
        write_sp(1'b0, 16'h0100);
        check({tag, " idle addr R12"}, mem_addr_o, 16'h0100);
        push_i = 1; #1;
        check({tag, " push addr"}, mem_addr_o, push_addr);
        step();
        check({tag, " push sp"}, main_sp_o, push_sp);
        pop_i = 1; #1;
        check({tag, " pop addr"}, mem_addr_o, pop_addr);
        step();
        check({tag, " pop sp"}, main_sp_o, 16'h0100);
    endtask

    task automatic t_banks();
        mode_i = 2'b00; bank_sel_i = 0;
        write_sp(1'b0, 16'h0100);
        write_sp(1'b1, 16'h0200);
        bank_sel_i = 1; #1;
        check("R10 active follows select", active_sp_o, 16'h0200);
        push_i = 1;
        step();
        check("R6 proc moved", proc_sp_o, 16'h01FE);
        check("R6 main untouched", main_sp_o, 16'h0100);
        bank_sel_i = 0;
        step();
        check("R10 main kept", main_sp_o, 16'h0100);
        check("R10 proc kept", proc_sp_o, 16'h01FE);
        check("R10 active main", active_sp_o, 16'h0100);
    endtask

    task automatic t_reset_load();
        rst_load_i = 1; rst_data_i = 16'h2000;
        step();
        check("R7 main loaded", main_sp_o, 16'h2000);
        check("R7 no fault", {15'b0, align_fault_o}, 16'h0);
    endtask

    task automatic t_align();
        write_sp(1'b1, 16'h0123);
        check("R8 proc even", proc_sp_o, 16'h0122);
        check("R8 fault raised", {15'b0, align_fault_o}, 16'h1);
        step();
        check("R8 fault one cycle", {15'b0, align_fault_o}, 16'h0);
        rst_load_i = 1; rst_data_i = 16'h3001;
        step();
        check("R8 load even", main_sp_o, 16'h3000);
        check("R8 load fault", {15'b0, align_fault_o}, 16'h1);
    endtask

    task automatic t_conflict();
        bank_sel_i = 0; mode_i = 2'b10;
        write_sp(1'b0, 16'h0400);
        push_i = 1; pop_i = 1;
        step();
        check("R9 main held", main_sp_o, 16'h0400);
        check("R9 err set", {15'b0, proto_err_o}, 16'h1);
        step();
        check("R9 err one cycle", {15'b0, proto_err_o}, 16'h0);
    endtask

    task automatic t_priority();
        bank_sel_i = 0; mode_i = 2'b00;
        rst_load_i = 1; rst_data_i = 16'h1000;
        wr_en_i = 1; wr_bank_i = 0; wr_data_i = 16'h0500;
        step();
        check("R11 load beats write", main_sp_o, 16'h1000);
        wr_en_i = 1; wr_bank_i = 0; wr_data_i = 16'h0600; push_i = 1;
        step();
        check("R11 write beats push", main_sp_o, 16'h0600);
    endtask

    initial begin
        #(CLK_PER * 5000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_mode(2'b00, "R2", 16'h00FE, 16'h00FE, 16'h00FE);
        t_mode(2'b01, "R3", 16'h0100, 16'h00FE, 16'h0100);
        t_mode(2'b10, "R4", 16'h0102, 16'h0102, 16'h0102);
        t_mode(2'b11, "R5", 16'h0100, 16'h0102, 16'h0100);
        t_banks();
        t_reset_load();
        t_align();
        t_conflict();
        t_priority();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule